// File: doc/BRIEF.md
# PHY Configuration Request Bridge

This block connects a host register bus to the 12-bit-address, 8-bit-data configuration space inside a PHY. The host writes one 32-bit request word that holds an opcode, a target address and write data. The bridge then raises a busy flag, carries out a read, a write or a clear of the configuration space, and clears the flag after a fixed latency. The host polls a completion register for the busy flag, a sticky overrun flag and the returned read byte.

The window also holds the plain PHY control registers: reset release, shutdown release, high-speed frequency band and configuration clock band. It also holds an ownership register that gives the configuration space either to the PHY's own state machine or to the bridge. In this project an internal byte array stands in for the PHY configuration space.

Top module: `phy_cfg_bridge`

## Requirements
- R1: After synchronous reset, every register in the window (offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18) reads 0, and all PHY control outputs are 0.
- R2: Offset 0x00 bit 0 drives the reset-release output. Offset 0x04 bit 0 drives the shutdown-release output. Offset 0x08 bits 6:0 drive the frequency band output. Offset 0x0C bits 7:0 drive the clock band output. Each of these reads back with unused bits at 0, and outputs change only on a host write to their offset.
- R3: Offset 0x10 bit 0 is the ownership bit: 0 gives the configuration space to the PHY state machine and 1 gives it to the bridge. It drives an output and reads back.
- R4: A write to offset 0x14 submits a request. Opcode is in bits 1:0, address in bits 15:4 and write data in bits 23:16. Opcode 0 reads, 1 writes, 2 clears the space and 3 is reserved. A read of 0x14 returns the last accepted request word.
- R5: Completion register 0x18 bit 0 (busy) reads 1 for exactly 4 cycles after the cycle in which a request is accepted, then reads 0.
- R6: After a read completes, completion bits 15:8 hold the byte last written to that address, or 0 if the address was never written since the last clear. A write completion leaves bits 15:8 unchanged.
- R7: The write data field of a read request has no effect on the configuration space.
- R8: A request written while busy is 1 is dropped. It also sets completion bit 2, which stays set until the host writes 0x18 with bit 2 set.
- R9: A clear request (opcode 2) makes every address read 0 afterwards and sets completion bits 15:8 to 0.
- R10: While the ownership bit is 0, requests are accepted and keep the same busy timing. They touch nothing in the configuration space, and a completed request sets bits 15:8 to 0.
- R11: A reserved opcode (3) completes with normal busy timing, sets bits 15:8 to 0 and changes no stored byte.
- R12: A host read returns the register value on host_rdata one clock after the read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Byte offset within the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| phy_rst_n | output | 1 | PHY reset release |
| phy_shut_n | output | 1 | PHY shutdown release |
| phy_hsband | output | 7 | High-speed frequency band |
| phy_clkband | output | 8 | Configuration clock band |
| cfg_by_bridge | output | 1 | Configuration space owned by the bridge |

## Verification
A vector table drives writes and reads with data and address patterns. These include the lowest and highest addresses, alternating bit patterns, a never-written address and a read carrying non-zero write data, which separates address decoding faults from data path faults. Directed tests then count busy cycles by polling, submit a second request while busy, and issue a clear request. They also run requests with the ownership bit at 0 and submit the reserved opcode. Each test ends by reading stored bytes back with ownership at 1, to show what did or did not change.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CLEAR = 2'd2,
    OP_RSVD  = 2'd3
  } cfg_op_e;

  localparam logic [7:0] OFS_RSTN   = 8'h00;
  localparam logic [7:0] OFS_SHUTN  = 8'h04;
  localparam logic [7:0] OFS_HSBAND = 8'h08;
  localparam logic [7:0] OFS_CKBAND = 8'h0C;
  localparam logic [7:0] OFS_OWNER  = 8'h10;
  localparam logic [7:0] OFS_REQ    = 8'h14;
  localparam logic [7:0] OFS_DONE   = 8'h18;

  localparam int REQ_OP_LSB   = 0;
  localparam int REQ_ADDR_LSB = 4;
  localparam int REQ_DATA_LSB = 16;
  localparam int DONE_BUSY    = 0;
  localparam int DONE_OVR     = 2;
  localparam int DONE_RD_LSB  = 8;
endpackage

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq #(
  parameter int AW  = 12,
  parameter int DW  = 8,
  parameter int LAT = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push,
  input  logic [31:0]            req_word,
  input  logic                   owner,
  input  logic                   ovr_clr,
  output logic                   busy,
  output logic                   ovr,
  output logic                   fire,
  output phy_cfg_pkg::cfg_op_e   op,
  output logic [AW-1:0]          addr,
  output logic [DW-1:0]          wdata,
  output logic                   live,
  output logic [31:0]            last_req
);
  import phy_cfg_pkg::*;
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic          busy_q, ovr_q, live_q;
  logic [CW-1:0] cnt_q;
  cfg_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [31:0]   word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      live_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
      word_q <= '0;
    end else begin
      if (ovr_clr) ovr_q <= 1'b0;
      if (push && busy_q) ovr_q <= 1'b1;
      if (push && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_INIT;
        op_q   <= cfg_op_e'(req_word[REQ_OP_LSB +: 2]);
        addr_q <= req_word[REQ_ADDR_LSB +: AW];
        data_q <= req_word[REQ_DATA_LSB +: DW];
        live_q <= owner;
        word_q <= req_word;
      end
      if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign ovr      = ovr_q;
  assign fire     = busy_q && (cnt_q == '0);
  assign op       = op_q;
  assign addr     = addr_q;
  assign wdata    = data_q;
  assign live     = live_q;
  assign last_req = word_q;

  // R5: busy holds for the full latency window
  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(busy_q, LAT));
  // R8: a request arriving while busy leaves the latched request alone
  p_drop_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (push && busy_q) |=> ($stable(addr_q) && $stable(data_q) && ovr_q));
  // R8: overrun flag is sticky until cleared
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !ovr_clr) |=> ovr_q);
endmodule

// File: rtl/phy_cfg_mem.sv
module phy_cfg_mem #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic                 live,
  input  phy_cfg_pkg::cfg_op_e op,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata
);
  import phy_cfg_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    raw_q;
  logic [DW-1:0]    rd_q;
  logic             act;

  assign act = fire && live;

  always_ff @(posedge clk) begin
    if (act && op == OP_WRITE) mem[addr] <= wdata;
    raw_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (act && op == OP_CLEAR) begin
      vld_q <= '0;
    end else if (act && op == OP_WRITE) begin
      vld_q[addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (fire) begin
      if (act && op == OP_READ) rd_q <= vld_q[addr] ? raw_q : '0;
      else if (!act || op != OP_WRITE) rd_q <= '0;
    end
  end

  assign rdata = rd_q;

  // R9: clear request wipes the returned byte
  p_clear_rdata_r9: assert property (@(posedge clk) disable iff (rst)
    (act && op == OP_CLEAR) |=> (rd_q == '0));
  // R10: without ownership nothing is returned
  p_noaccess_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && !live) |=> (rd_q == '0));
endmodule

// File: rtl/phy_cfg_bridge.sv
module phy_cfg_bridge #(
  parameter int HAW = 8,
  parameter int AW  = 12,
  parameter int DW  = 8,
  parameter int LAT = 4,
  parameter int BW  = 7,
  parameter int KW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [HAW-1:0] host_addr,
  input  logic [31:0]    host_wdata,
  output logic [31:0]    host_rdata,
  output logic           phy_rst_n,
  output logic           phy_shut_n,
  output logic [BW-1:0]  phy_hsband,
  output logic [KW-1:0]  phy_clkband,
  output logic           cfg_by_bridge
);
  import phy_cfg_pkg::*;

  logic          rstn_q, shutn_q, owner_q;
  logic [BW-1:0] hsb_q;
  logic [KW-1:0] ckb_q;
  logic [31:0]   rdata_q, done_word, rd_mux;
  logic          push, ovr_clr, busy, ovr, fire, live;
  cfg_op_e       op;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_wdata, cfg_rd;
  logic [31:0]   last_req;

  assign push    = host_wr && (host_addr == HAW'(OFS_REQ));
  assign ovr_clr = host_wr && (host_addr == HAW'(OFS_DONE)) && host_wdata[DONE_OVR];

  always_ff @(posedge clk) begin
    if (rst) begin
      rstn_q  <= 1'b0;
      shutn_q <= 1'b0;
      owner_q <= 1'b0;
      hsb_q   <= '0;
      ckb_q   <= '0;
    end else if (host_wr) begin
      case (host_addr)
        HAW'(OFS_RSTN):   rstn_q  <= host_wdata[0];
        HAW'(OFS_SHUTN):  shutn_q <= host_wdata[0];
        HAW'(OFS_HSBAND): hsb_q   <= host_wdata[BW-1:0];
        HAW'(OFS_CKBAND): ckb_q   <= host_wdata[KW-1:0];
        HAW'(OFS_OWNER):  owner_q <= host_wdata[0];
        default: ;
      endcase
    end
  end

  phy_cfg_seq #(.AW(AW), .DW(DW), .LAT(LAT)) u_seq (
    .clk(clk), .rst(rst), .push(push), .req_word(host_wdata),
    .owner(owner_q), .ovr_clr(ovr_clr), .busy(busy), .ovr(ovr),
    .fire(fire), .op(op), .addr(op_addr), .wdata(op_wdata),
    .live(live), .last_req(last_req)
  );

  phy_cfg_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst(rst), .fire(fire), .live(live), .op(op),
    .addr(op_addr), .wdata(op_wdata), .rdata(cfg_rd)
  );

  always_comb begin
    done_word = '0;
    done_word[DONE_BUSY] = busy;
    done_word[DONE_OVR]  = ovr;
    done_word[DONE_RD_LSB +: DW] = cfg_rd;
  end

  always_comb begin
    rd_mux = '0;
    case (host_addr)
      HAW'(OFS_RSTN):   rd_mux[0]      = rstn_q;
      HAW'(OFS_SHUTN):  rd_mux[0]      = shutn_q;
      HAW'(OFS_HSBAND): rd_mux[BW-1:0] = hsb_q;
      HAW'(OFS_CKBAND): rd_mux[KW-1:0] = ckb_q;
      HAW'(OFS_OWNER):  rd_mux[0]      = owner_q;
      HAW'(OFS_REQ):    rd_mux         = last_req;
      HAW'(OFS_DONE):   rd_mux         = done_word;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata    = rdata_q;
  assign phy_rst_n     = rstn_q;
  assign phy_shut_n    = shutn_q;
  assign phy_hsband    = hsb_q;
  assign phy_clkband   = ckb_q;
  assign cfg_by_bridge = owner_q;

  // R2: control outputs move only on a host write
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !host_wr |=> ($stable(phy_hsband) && $stable(phy_clkband) && $stable(phy_rst_n)));
  // R12: host data only moves on a read
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

// File: tb/phy_cfg_bridge_test.sv
module phy_cfg_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_rst_n, phy_shut_n, cfg_by_bridge;
  logic [6:0]  phy_hsband;
  logic [7:0]  phy_clkband;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  phy_cfg_bridge uut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .phy_rst_n(phy_rst_n), .phy_shut_n(phy_shut_n), .phy_hsband(phy_hsband),
    .phy_clkband(phy_clkband), .cfg_by_bridge(cfg_by_bridge)
  );

  // vector: {op, addr, wdata, expected read byte}
  localparam logic [29:0] VEC [10] = '{
    {2'd1, 12'h005, 8'hA5, 8'h00},
    {2'd1, 12'hFFF, 8'h3C, 8'h00},
    {2'd1, 12'h000, 8'h81, 8'h00},
    {2'd0, 12'h005, 8'h00, 8'hA5},
    {2'd0, 12'hFFF, 8'h00, 8'h3C},
    {2'd0, 12'h000, 8'h00, 8'h81},
    {2'd0, 12'h123, 8'h00, 8'h00},
    {2'd0, 12'h00A, 8'hFF, 8'h00},
    {2'd0, 12'h00A, 8'h00, 8'h00},
    {2'd1, 12'h800, 8'h5A, 8'h00}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic req(input logic [1:0] op, input logic [11:0] a, input logic [7:0] d);
    wr(8'h14, {8'h00, d, a, 2'b00, op});
  endtask

  // polls completion until idle; returns number of busy polls and final word
  task automatic wait_idle(output int nb, output logic [31:0] w);
    nb = 0;
    for (int i = 0; i < 20; i++) begin
      rd(8'h18, w);
      if (!w[0]) break;
      nb++;
    end
  endtask

  initial begin
    logic [31:0] w;
    int nb;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(8'(a), w);
      check($sformatf("R1 reg 0x%02h", a), w, 32'h0);
    end
    check("R1 outputs", {phy_rst_n, phy_shut_n, cfg_by_bridge, 1'b0, phy_hsband, 1'b0, phy_clkband}, 32'h0);

    // R2: control registers
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'h1); wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'h0000_01AB);
    rd(8'h00, w); check("R2 rstn readback", w, 32'h1);
    rd(8'h08, w); check("R2 hsband readback", w, 32'h7F);
    rd(8'h0C, w); check("R2 clkband readback", w, 32'hAB);
    check("R2 outputs", {22'h0, phy_rst_n, phy_shut_n, phy_clkband}, {22'h0, 2'b11, 8'hAB});
    check("R2 hsband output", {25'h0, phy_hsband}, 32'h7F);

    // R3: ownership
    wr(8'h10, 32'h1);
    rd(8'h10, w); check("R3 owner readback", w, 32'h1);
    check("R3 owner output", {31'h0, cfg_by_bridge}, 32'h1);

    // R4 R6 R7: vector table
    foreach (VEC[i]) begin
      req(VEC[i][29:28], VEC[i][27:16], VEC[i][15:8]);
      wait_idle(nb, w);
      if (VEC[i][29:28] == 2'd0)
        check($sformatf("R6 R7 vector %0d read byte", i), {24'h0, w[15:8]}, {24'h0, VEC[i][7:0]});
    end
    rd(8'h14, w); check("R4 last request word", w, {8'h00, 8'h5A, 12'h800, 4'h1});

    // R5: busy length
    req(2'd0, 12'h800, 8'h00);
    wait_idle(nb, w);
    check("R5 busy polls", nb, 4);
    check("R6 read 0x800", {24'h0, w[15:8]}, 32'h5A);
    req(2'd1, 12'h801, 8'h44);
    wait_idle(nb, w);
    check("R6 write keeps read byte", {24'h0, w[15:8]}, 32'h5A);

    // R8: request while busy
    req(2'd1, 12'h040, 8'h77);
    req(2'd1, 12'h040, 8'h99);
    wait_idle(nb, w);
    check("R8 overrun flag set", {31'h0, w[2]}, 32'h1);
    req(2'd0, 12'h040, 8'h00);
    wait_idle(nb, w);
    check("R8 dropped write", {24'h0, w[15:8]}, 32'h77);
    check("R8 overrun sticky", {31'h0, w[2]}, 32'h1);
    wr(8'h18, 32'h4);
    rd(8'h18, w); check("R8 overrun cleared", w, 32'h0000_7700);

    // R9: clear opcode
    req(2'd0, 12'h005, 8'h00); wait_idle(nb, w);
    check("R9 pre-clear byte", {24'h0, w[15:8]}, 32'hA5);
    req(2'd2, 12'h000, 8'h00); wait_idle(nb, w);
    check("R9 read byte zeroed", w, 32'h0);
    req(2'd0, 12'h005, 8'h00); wait_idle(nb, w);
    check("R9 0x005 cleared", {24'h0, w[15:8]}, 32'h0);
    req(2'd0, 12'hFFF, 8'h00); wait_idle(nb, w);
    check("R9 0xFFF cleared", {24'h0, w[15:8]}, 32'h0);

    // R10: ownership 0
    req(2'd1, 12'h006, 8'h66); wait_idle(nb, w);
    req(2'd0, 12'h006, 8'h00); wait_idle(nb, w);
    check("R10 setup byte", {24'h0, w[15:8]}, 32'h66);
    wr(8'h10, 32'h0);
    req(2'd0, 12'h006, 8'h00); wait_idle(nb, w);
    check("R10 busy polls", nb, 4);
    check("R10 read byte forced 0", {24'h0, w[15:8]}, 32'h0);
    req(2'd1, 12'h006, 8'h22); wait_idle(nb, w);
    req(2'd2, 12'h000, 8'h00); wait_idle(nb, w);
    wr(8'h10, 32'h1);
    req(2'd0, 12'h006, 8'h00); wait_idle(nb, w);
    check("R10 space untouched", {24'h0, w[15:8]}, 32'h66);

    // R11: reserved opcode
    req(2'd3, 12'h006, 8'h11); wait_idle(nb, w);
    check("R11 busy polls", nb, 4);
    check("R11 read byte 0", {24'h0, w[15:8]}, 32'h0);
    req(2'd0, 12'h006, 8'h00); wait_idle(nb, w);
    check("R11 byte unchanged", {24'h0, w[15:8]}, 32'h66);

    // R12: read latency, data appears one clock after the sampled read
    host_rd = 1'b1; host_addr = 8'h0C;
    @(posedge clk); #1;
    host_rd = 1'b0;
    check("R12 rdata after one clock", host_rdata, 32'hAB);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule